// File: doc/BRIEF.md
# Control Store Image Loader

This block is a sequencer that copies a microcode image from a word-addressed memory into a writable control store that is 36 bits wide. The image is a run of records, each made of three consecutive 16-bit memory words. The loader reads the records one at a time. From each record it rebuilds a 12-bit control-store address and a 36-bit instruction, and then writes that instruction into the store in two halves.

A record whose address field is all ones ends the image. That record is never written to the store. Its second word is the entry address of the code that was just loaded. Its third word is a checksum, which the loader skips: checking it is left to other logic. When the image ends, the loader pulses `done_o`. If `no_jump_i` is low at that moment, it also pulses `jump_o` and presents the entry address.

A start command loads the read pointer from `base_ptr_i`. A continue command keeps the pointer where the previous image ended, so an overlay stored right after that image loads with no new base. Memory reads use a valid/ready request and a separate response strobe. Only one read is outstanding at a time, and the loader waits as long as the memory needs.

Top module: `cs_image_loader`

## Requirements
- R1: On a start command, the first read goes to `base_ptr_i`. Each accepted read request moves the pointer up by exactly one, so the words of an image are read at consecutive addresses.
- R2: The control-store address is bits 15:4 of the first word of a record.
- R3: Instruction bit 0 is the most significant bit of the 36-bit word. Bits 0–15 come from the second word, bits 16–31 from the third word, and bits 32–35 from bits 3:0 of the first word.
- R4: A record whose address field is 12'hFFF ends the image and produces no control-store write. Every other record, 12'hFFE included, is written.
- R5: Each instruction takes two writes to the same address, on two consecutive cycles. The first has `cs_half_o`=0 and data {bits 0–15, bits 32–35} (bits 0–15 in data[19:4]). The second has `cs_half_o`=1 and data {4'h0, bits 16–31}.
- R6: At the end of an image, `jump_o` pulses with `done_o` when `no_jump_i` is 0, and `jump_addr_o` then holds the terminator's second word. When `no_jump_i` is 1, no jump is raised. The checksum word has no effect on any output.
- R7: A continue command resumes reading at the address that follows the last word read, without reloading the pointer.
- R8: A read request holds its valid and address until ready is seen. The loader does not proceed until the response strobe arrives, whatever the delay.
- R9: `done_o` is a one-cycle pulse, and `busy_o` is low in that cycle. `busy_o` is high from the cycle after an accepted command until done. Commands are ignored while busy. When start and continue arrive together, start wins.
- R10: After reset, busy, done, jump, read request and store write are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin loading at base_ptr_i |
| cont_i | input | 1 | Resume loading at the current pointer |
| base_ptr_i | input | 16 | Base address of the image for start |
| no_jump_i | input | 1 | Low bit of the caller's flag: 1 suppresses the jump |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_addr_o | output | 16 | Read request word address |
| rd_req_ready_i | input | 1 | Memory accepts the request |
| rd_rsp_valid_i | input | 1 | Read data strobe |
| rd_rsp_data_i | input | 16 | Read data |
| cs_we_o | output | 1 | Control-store write strobe |
| cs_half_o | output | 1 | 0 for the first write of an instruction, 1 for the second |
| cs_addr_o | output | 12 | Control-store address |
| cs_wdata_o | output | 20 | Write data for the selected half |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | One-cycle pulse when the image is finished |
| jump_o | output | 1 | One-cycle pulse requesting a jump to jump_addr_o |
| jump_addr_o | output | 16 | Entry address from the terminator record |

## Verification
Two events can land on the same cycle: the done pulse of one image and the next command. The bench raises continue on the very cycle that `done_o` is seen, and then expects `busy_o` to rise one cycle later and the overlay's reads to start at the next pointer. A second coincidence is start and continue raised together, with a start command poked in while the loader is busy. The reference model expects reads from the new base for the first case and an unchanged address stream for the second. Every read address and every store write is compared against the model's queues on each clock.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_REQ  = 2'd1,
        F_WAIT = 2'd2
    } fetch_st_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ISSUE = 3'd1,
        S_WAIT  = 3'd2,
        S_EVAL  = 3'd3,
        S_WR0   = 3'd4,
        S_WR1   = 3'd5
    } seq_st_e;

    localparam int unsigned REC_WORDS = 3;

endpackage

// File: rtl/ldr_fetch.sv
module ldr_fetch
    import ldr_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_ptr_i,
    input  logic          go_i,
    output logic          req_valid_o,
    output logic [AW-1:0] req_addr_o,
    input  logic          req_ready_i,
    input  logic          rsp_valid_i,
    input  logic [DW-1:0] rsp_data_i,
    output logic          word_vld_o,
    output logic [DW-1:0] word_o
);

    typedef struct packed {
        fetch_st_e     st;
        logic [AW-1:0] ptr;
        logic          vld;
        logic [DW-1:0] word;
    } fetch_t;

    fetch_t fq_q, fq_d;

    always_comb begin
        fq_d     = fq_q;
        fq_d.vld = 1'b0;
        if (load_i) begin
            fq_d.ptr = load_ptr_i;
        end
        unique case (fq_q.st)
            F_IDLE: begin
                if (go_i) fq_d.st = F_REQ;
            end
            F_REQ: begin
                if (req_ready_i) begin
                    fq_d.ptr = fq_q.ptr + AW'(1);
                    fq_d.st  = F_WAIT;
                end
            end
            F_WAIT: begin
                if (rsp_valid_i) begin
                    fq_d.word = rsp_data_i;
                    fq_d.vld  = 1'b1;
                    fq_d.st   = F_IDLE;
                end
            end
            default: fq_d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fq_q <= '{st: F_IDLE, ptr: '0, vld: 1'b0, word: '0};
        end else begin
            fq_q <= fq_d;
        end
    end

    assign req_valid_o = (fq_q.st == F_REQ);
    assign req_addr_o  = fq_q.ptr;
    assign word_vld_o  = fq_q.vld;
    assign word_o      = fq_q.word;

    // R1: every accepted request advances the pointer by one
    p_ptr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ready_i) |=> (req_addr_o == $past(req_addr_o) + AW'(1)));

    // R8: an unaccepted request keeps valid and address
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

    // R8: a word is only delivered after the response strobe
    p_word_after_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |-> $past(rsp_valid_i));

endmodule

// File: rtl/ldr_record.sv
module ldr_record
    import ldr_pkg::*;
#(
    parameter int unsigned DW  = 16,
    parameter int unsigned CAW = 12,
    parameter int unsigned IW  = 36
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear_i,
    input  logic           word_vld_i,
    input  logic [DW-1:0]  word_i,
    output logic           last_o,
    output logic [CAW-1:0] cs_addr_o,
    output logic [IW-1:0]  instr_o,
    output logic           term_o,
    output logic [DW-1:0]  start_addr_o
);

    localparam int unsigned LOW_W = IW - 2 * DW;
    localparam int unsigned IDX_W = $clog2(REC_WORDS);

    typedef struct packed {
        logic [IDX_W-1:0]          idx;
        logic [REC_WORDS-1:0][DW-1:0] w;
    } rec_t;

    rec_t rq_q, rq_d;
    logic [REC_WORDS-1:0] slot_hit;

    // one capture enable per record slot
    for (genvar g = 0; g < REC_WORDS; g++) begin : g_slot
        assign slot_hit[g] = word_vld_i && (rq_q.idx == IDX_W'(g));
    end

    always_comb begin
        rq_d = rq_q;
        if (clear_i) begin
            rq_d.idx = '0;
        end else if (word_vld_i) begin
            for (int k = 0; k < REC_WORDS; k++) begin
                if (slot_hit[k]) rq_d.w[k] = word_i;
            end
            rq_d.idx = (rq_q.idx == IDX_W'(REC_WORDS - 1)) ? '0 : rq_q.idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_q <= '0;
        end else begin
            rq_q <= rq_d;
        end
    end

    assign last_o       = slot_hit[REC_WORDS-1];
    assign cs_addr_o    = rq_q.w[0][DW-1:LOW_W];                        // R2
    assign instr_o      = {rq_q.w[1], rq_q.w[2], rq_q.w[0][LOW_W-1:0]}; // R3
    assign term_o       = &cs_addr_o;                                   // R4
    assign start_addr_o = rq_q.w[1];

    // R2: after the third word the slot counter wraps to the first
    p_last_wraps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !clear_i) |=> (rq_q.idx == '0));

    p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rq_q.idx < IDX_W'(REC_WORDS));

endmodule

// File: rtl/cs_image_loader.sv
module cs_image_loader
    import ldr_pkg::*;
#(
    parameter int unsigned AW  = 16,
    parameter int unsigned DW  = 16,
    parameter int unsigned CAW = 12,
    parameter int unsigned IW  = 36,
    localparam int unsigned LOW_W  = IW - 2 * DW,
    localparam int unsigned HALF_W = DW + LOW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cont_i,
    input  logic [AW-1:0]     base_ptr_i,
    input  logic              no_jump_i,
    output logic              rd_req_valid_o,
    output logic [AW-1:0]     rd_req_addr_o,
    input  logic              rd_req_ready_i,
    input  logic              rd_rsp_valid_i,
    input  logic [DW-1:0]     rd_rsp_data_i,
    output logic              cs_we_o,
    output logic              cs_half_o,
    output logic [CAW-1:0]    cs_addr_o,
    output logic [HALF_W-1:0] cs_wdata_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              jump_o,
    output logic [DW-1:0]     jump_addr_o
);

    typedef struct packed {
        seq_st_e       st;
        logic          done;
        logic          jump;
        logic [DW-1:0] jaddr;
    } seq_t;

    seq_t sq_q, sq_d;

    logic           cmd_take;
    logic           word_vld;
    logic [DW-1:0]  word;
    logic           rec_last;
    logic [CAW-1:0] rec_addr;
    logic [IW-1:0]  rec_instr;
    logic           rec_term;
    logic [DW-1:0]  rec_start;

    assign cmd_take = (sq_q.st == S_IDLE) && (start_i || cont_i);

    ldr_fetch #(.AW(AW), .DW(DW)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (cmd_take && start_i),
        .load_ptr_i  (base_ptr_i),
        .go_i        (sq_q.st == S_ISSUE),
        .req_valid_o (rd_req_valid_o),
        .req_addr_o  (rd_req_addr_o),
        .req_ready_i (rd_req_ready_i),
        .rsp_valid_i (rd_rsp_valid_i),
        .rsp_data_i  (rd_rsp_data_i),
        .word_vld_o  (word_vld),
        .word_o      (word)
    );

    ldr_record #(.DW(DW), .CAW(CAW), .IW(IW)) u_record (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (cmd_take),
        .word_vld_i   (word_vld),
        .word_i       (word),
        .last_o       (rec_last),
        .cs_addr_o    (rec_addr),
        .instr_o      (rec_instr),
        .term_o       (rec_term),
        .start_addr_o (rec_start)
    );

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        sq_d.jump = 1'b0;
        unique case (sq_q.st)
            S_IDLE: begin
                if (start_i || cont_i) sq_d.st = S_ISSUE;
            end
            S_ISSUE: sq_d.st = S_WAIT;
            S_WAIT: begin
                if (word_vld) sq_d.st = rec_last ? S_EVAL : S_ISSUE;
            end
            S_EVAL: begin
                if (rec_term) begin
                    sq_d.st    = S_IDLE;
                    sq_d.done  = 1'b1;
                    sq_d.jump  = !no_jump_i;
                    sq_d.jaddr = rec_start;
                end else begin
                    sq_d.st = S_WR0;
                end
            end
            S_WR0:   sq_d.st = S_WR1;
            S_WR1:   sq_d.st = S_ISSUE;
            default: sq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '{st: S_IDLE, done: 1'b0, jump: 1'b0, jaddr: '0};
        end else begin
            sq_q <= sq_d;
        end
    end

    always_comb begin
        cs_we_o    = 1'b0;
        cs_half_o  = 1'b0;
        cs_wdata_o = '0;
        if (sq_q.st == S_WR0) begin
            cs_we_o    = 1'b1;
            cs_wdata_o = {rec_instr[IW-1 -: DW], rec_instr[LOW_W-1:0]};
        end else if (sq_q.st == S_WR1) begin
            cs_we_o    = 1'b1;
            cs_half_o  = 1'b1;
            cs_wdata_o = HALF_W'(rec_instr[LOW_W +: DW]);
        end
    end

    assign cs_addr_o   = rec_addr;
    assign busy_o      = (sq_q.st != S_IDLE);
    assign done_o      = sq_q.done;
    assign jump_o      = sq_q.jump;
    assign jump_addr_o = sq_q.jaddr;

    // R4: the terminator address never reaches the store
    p_no_term_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_we_o |-> (cs_addr_o != {CAW{1'b1}}));

    // R5: first half is followed at once by second half at the same address
    p_two_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_we_o && !cs_half_o) |=> (cs_we_o && cs_half_o && $stable(cs_addr_o)));

    // R6: a jump only comes with the done pulse
    p_jump_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        jump_o |-> done_o);

    // R9: done lasts one cycle and the loader is idle then
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8: no read request and store write in the same cycle
    p_req_or_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_valid_o && cs_we_o));

endmodule

// File: tb/tb_cs_image_loader.sv
`timescale 1ns/100ps
module tb_cs_image_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, cont_i = 1'b0, no_jump_i = 1'b0;
    logic [15:0] base_ptr_i = '0;
    logic        rd_req_valid_o, rd_req_ready_i = 1'b0;
    logic [15:0] rd_req_addr_o;
    logic        rd_rsp_valid_i = 1'b0;
    logic [15:0] rd_rsp_data_i = '0;
    logic        cs_we_o, cs_half_o;
    logic [11:0] cs_addr_o;
    logic [19:0] cs_wdata_o;
    logic        busy_o, done_o, jump_o;
    logic [15:0] jump_addr_o;

    always #2.5 clk = ~clk;

    cs_image_loader dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
        .base_ptr_i(base_ptr_i), .no_jump_i(no_jump_i),
        .rd_req_valid_o(rd_req_valid_o), .rd_req_addr_o(rd_req_addr_o),
        .rd_req_ready_i(rd_req_ready_i), .rd_rsp_valid_i(rd_rsp_valid_i),
        .rd_rsp_data_i(rd_rsp_data_i), .cs_we_o(cs_we_o), .cs_half_o(cs_half_o),
        .cs_addr_o(cs_addr_o), .cs_wdata_o(cs_wdata_o), .busy_o(busy_o),
        .done_o(done_o), .jump_o(jump_o), .jump_addr_o(jump_addr_o)
    );

    int total = 0, bad = 0, cyc = 0;
    logic [15:0] mem [0:255];
    logic [32:0] expq [$];      // {half, addr[11:0], data[19:0]}
    int          model_ptr = 0;
    int          wp = 0;
    int          ready_mode = 0, lat_cfg = 0, ncnt = 0;
    bit          pend = 0;
    int          pcnt = 0;
    logic [15:0] paddr = '0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put(logic [15:0] w);
        mem[wp[7:0]] = w;
        wp++;
    endtask

    // R2, R3: build a record and its two expected store writes
    task automatic rec(logic [11:0] a, logic [35:0] ins);
        put({a, ins[3:0]});
        put(ins[35:20]);
        put(ins[19:4]);
        expq.push_back({1'b0, a, ins[35:20], ins[3:0]});
        expq.push_back({1'b1, a, 4'h0, ins[19:4]});
    endtask

    task automatic term(logic [15:0] entry, logic [15:0] cks);
        put({12'hFFF, 4'h9});
        put(entry);
        put(cks);
    endtask

    // memory model and per-clock comparison against the reference queues
    always @(negedge clk) begin
        if (rst_n) begin
            logic [32:0] e;
            bit rdy;
            ncnt++;
            rd_rsp_valid_i = 1'b0;
            if (pend) begin
                if (pcnt == 0) begin
                    rd_rsp_valid_i = 1'b1;
                    rd_rsp_data_i  = mem[paddr[7:0]];
                    pend = 0;
                end else begin
                    pcnt--;
                end
            end
            rdy = (ready_mode == 0) ? 1'b1 : ((ncnt % 3) == 0);
            rd_req_ready_i = rdy;
            if (rd_req_valid_o && rdy) begin
                chk(rd_req_addr_o == model_ptr[15:0], "R1", "read address", rd_req_addr_o, model_ptr);
                model_ptr++;
                pend  = 1;
                pcnt  = lat_cfg;
                paddr = rd_req_addr_o;
            end
            if (cs_we_o) begin
                if (expq.size() == 0) begin
                    chk(0, "R4", "unexpected store write addr", cs_addr_o, 0);
                end else begin
                    e = expq.pop_front();
                    chk(cs_half_o == e[32], "R5", "write half", cs_half_o, e[32]);
                    chk(cs_addr_o == e[31:20], "R2", "store address", cs_addr_o, e[31:20]);
                    chk(cs_wdata_o == e[19:0], "R3", "store data", cs_wdata_o, e[19:0]);
                end
            end
        end
    end

    // run one image; returns at the negedge where done_o is seen
    task automatic run(bit use_start, bit both, logic [15:0] base, bit nj, bit poke,
                       bit now, bit exp_jump, logic [15:0] exp_entry, int exp_end,
                       bit check_after);
        int n = 0;
        if (!now) @(negedge clk);
        start_i    = use_start;
        cont_i     = !use_start || both;
        base_ptr_i = base;
        no_jump_i  = nj;
        if (use_start) model_ptr = base;
        @(negedge clk);
        start_i = 1'b0;
        cont_i  = 1'b0;
        chk(busy_o == 1'b1, "R9", "busy after command", busy_o, 1);
        while (!done_o) begin
            chk(jump_o == 1'b0, "R6", "jump before done", jump_o, 0);
            if (poke && n == 6) begin
                start_i = 1'b1; cont_i = 1'b1; base_ptr_i = 16'h00F0;
            end
            if (poke && n == 7) begin
                start_i = 1'b0; cont_i = 1'b0;
            end
            n++;
            if (n > 4000) begin
                chk(0, "R9", "done never seen, cycles", n, 0);
                break;
            end
            @(negedge clk);
            if (!done_o)
                chk(busy_o == 1'b1, "R9", "busy during load", busy_o, 1);
        end
        chk(busy_o == 1'b0, "R9", "busy at done", busy_o, 0);
        chk(jump_o == exp_jump, "R6", "jump flag", jump_o, exp_jump);
        if (exp_jump)
            chk(jump_addr_o == exp_entry, "R6", "entry address", jump_addr_o, exp_entry);
        chk(expq.size() == 0, "R4", "writes left", expq.size(), 0);
        chk(model_ptr == exp_end, "R7", "final pointer", model_ptr, exp_end);
        if (check_after) begin
            @(negedge clk);
            chk(done_o == 1'b0, "R9", "done width", done_o, 0);
            chk(jump_o == 1'b0, "R6", "jump width", jump_o, 0);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(busy_o == 0, "R10", "busy", busy_o, 0);
        chk(done_o == 0, "R10", "done", done_o, 0);
        chk(jump_o == 0, "R10", "jump", jump_o, 0);
        chk(rd_req_valid_o == 0, "R10", "read request", rd_req_valid_o, 0);
        chk(cs_we_o == 0, "R10", "store write", cs_we_o, 0);

        // image A at 16, fast memory, jump taken, boundary address 12'hFFE written
        wp = 16;
        rec(12'h000, 36'h123456789);
        rec(12'hFFE, 36'hFEDCBA987);
        rec(12'h555, 36'h0F0F0F0F5);
        term(16'h0ABC, 16'hDEAD);
        ready_mode = 0; lat_cfg = 0;
        run(1, 0, 16'd16, 0, 0, 0, 1, 16'h0ABC, 28, 1);

        // overlay B via continue (R7), stalled memory (R8), jump suppressed
        rec(12'h010, 36'h111122223);
        rec(12'h011, 36'h444455556);
        term(16'h1234, 16'h0000);
        ready_mode = 1; lat_cfg = 2;
        run(0, 0, 16'h0000, 1, 0, 0, 0, 16'h0, 37, 0);

        // overlay C: continue raised in the very cycle of B's done pulse
        rec(12'h7FF, 36'hABCDEF012);
        term(16'h0777, 16'hFFFF);
        run(0, 0, 16'h0000, 0, 0, 1, 1, 16'h0777, 43, 1);

        // image D at 100: start and continue together, poke while busy (R9)
        wp = 100;
        for (int k = 0; k < 4; k++)
            rec(12'(12'h100 + k * 12'h111), 36'h0A5A5A5A0 + 36'(k * 36'h101010101));
        term(16'h0042, 16'h5A5A);
        ready_mode = 1; lat_cfg = 3;
        run(1, 1, 16'd100, 0, 1, 0, 1, 16'h0042, 115, 1);

        // image E at 200: terminator only, no writes (R4), different checksum (R6)
        wp = 200;
        term(16'hBEEF, 16'h1357);
        ready_mode = 0; lat_cfg = 1;
        run(1, 0, 16'd200, 0, 0, 0, 1, 16'hBEEF, 203, 1);

        repeat (3) @(negedge clk);
        chk(busy_o == 0, "R9", "idle at end", busy_o, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule